// File: doc/BRIEF.md
# Pin Event Interrupt Detector

This block watches a bank of general-purpose input pins and turns activity on them into latched per-pin interrupt flags. Each pin has four configuration bits. One sets its direction, and only pins configured as inputs can raise flags. One lets the pin's flag reach the summary request. One picks level or edge detection. One picks the polarity or edge that counts as active. Every pin passes through a synchronizer before detection, so the pins may be fully asynchronous to the block clock.

Software configures the block and services it through a small register port. Each write is a single cycle, and reads are combinational. A latched flag is cleared by writing a word with a 0 in that flag's position. A 1 in any position leaves the flag there untouched, so one pin can be acknowledged without a read-modify-write. The summary output is meant to feed one input of a parent interrupt controller.

Top module: `gpio_irq_detect`

## Requirements
- R1: Under reset every configuration register, every status flag and the summary output go to 0. This leaves every pin an input with its interrupt disabled, in rising-edge mode.
- R2: A write at address 0 (direction, 1 = output), 1 (enable, 1 = enabled), 2 (mode, 1 = level) or 3 (polarity, 1 = low/falling) is returned by a read of the same address after the write edge. Address 5 reads the synchronized pin levels. Addresses 6 and 7 read 0.
- R3: Every pin passes through a two-stage synchronizer. A pin change that is stable before clock edge k sets its status flag at edge k+2, and the flag is readable at address 4 after that edge.
- R4: In edge mode with polarity 0, a low-to-high transition on an input pin sets its flag once. The flag then stays set after the pin returns low.
- R5: In edge mode with polarity 1, only a high-to-low transition sets the flag. A rising transition leaves it clear.
- R6: In level mode the flag is set on every cycle in which the synchronized pin is at its active level: high for polarity 0, low for polarity 1. This includes the cycle of a clear write.
- R7: A pin whose direction bit is 1 never sets its flag, whatever its activity.
- R8: A write to address 4 clears exactly the flags whose data bit is 0. Flags whose data bit is 1 keep their value, and no other write or read changes a flag except a new event.
- R9: When a detected event and a clearing write hit the same flag in the same cycle, the flag ends set.
- R10: The summary output is 1 exactly when some flag is set and its enable bit is 1. Flags are still latched while their enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Asynchronous pin levels |
| reg_wr_i | input | 1 | Register write strobe for one cycle |
| reg_addr_i | input | 3 | Register address for read and write |
| reg_wdata_i | input | NPINS | Write data |
| reg_rdata_o | output | NPINS | Combinational read data for reg_addr_i |
| irq_o | output | 1 | Summary interrupt request |

## Verification
A pin change driven between edges reaches its status flag on the third rising edge: two synchronizer stages plus the flag register. That edge is also the first at which an edge-mode event can meet a clear write. A configuration or clear write takes effect on the edge that samples the strobe. The summary request follows the flags in the same cycle, with no extra register. The bench drives all inputs on the falling edge and samples 2 ns after each rising edge, so every directed check counts edges from the drive point. It also compares read data and the summary against a behavioural model after every edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Register port address width and the register decode.
    localparam int unsigned REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_DIR    = 3'd0,
        REG_ENABLE = 3'd1,
        REG_MODE   = 3'd2,
        REG_POL    = 3'd3,
        REG_STATUS = 3'd4,
        REG_PINS   = 3'd5
    } gpio_reg_e;

    // Per-pin trigger configuration that the detector consumes.
    typedef struct packed {
        logic is_output;
        logic level;
        logic invert;
    } pin_cfg_t;

    // Trigger kind: {level, invert}.
    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_HIGH = 2'b10,
        TRIG_LOW  = 2'b11
    } trig_e;

    function automatic trig_e trig_of(input pin_cfg_t c);
        return trig_e'({c.level, c.invert});
    endfunction

    function automatic logic trig_hit(input trig_e t, input logic now, input logic was);
        logic hit;
        case (t)
            TRIG_RISE: hit = now & ~was;
            TRIG_FALL: hit = ~now & was;
            TRIG_HIGH: hit = now;
            TRIG_LOW:  hit = ~now;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk_i) begin
        if (rst_i) chain[0] <= '0;
        else       chain[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i) chain[s] <= '0;
            else       chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[LAST];
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  wr_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [NPINS-1:0]      wdata_i,
    output logic [NPINS-1:0]      dir_o,
    output logic [NPINS-1:0]      en_o,
    output logic [NPINS-1:0]      mode_o,
    output logic [NPINS-1:0]      pol_o,
    output pin_cfg_t [NPINS-1:0]  cfg_o
);
    logic [NPINS-1:0] dir_q, en_q, mode_q, pol_q;
    gpio_reg_e        sel;

    assign sel = gpio_reg_e'(addr_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dir_q  <= '0;
            en_q   <= '0;
            mode_q <= '0;
            pol_q  <= '0;
        end else if (wr_i) begin
            case (sel)
                REG_DIR:    dir_q  <= wdata_i;
                REG_ENABLE: en_q   <= wdata_i;
                REG_MODE:   mode_q <= wdata_i;
                REG_POL:    pol_q  <= wdata_i;
                default:    ;
            endcase
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_cfg
        assign cfg_o[p] = '{is_output: dir_q[p], level: mode_q[p], invert: pol_q[p]};
    end

    assign dir_o  = dir_q;
    assign en_o   = en_q;
    assign mode_o = mode_q;
    assign pol_o  = pol_q;
endmodule

// File: rtl/gpio_irq_event.sv
module gpio_irq_event
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [NPINS-1:0]     level_i,
    input  pin_cfg_t [NPINS-1:0] cfg_i,
    output logic [NPINS-1:0]     hit_o
);
    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= '0;
        else       prev_q <= level_i;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        trig_e kind;
        assign kind     = trig_of(cfg_i[p]);
        assign hit_o[p] = ~cfg_i[p].is_output & trig_hit(kind, level_i[p], prev_q[p]);
    end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [NPINS-1:0] hit_i,
    input  logic             clr_i,
    input  logic [NPINS-1:0] keep_i,
    input  logic [NPINS-1:0] en_i,
    output logic [NPINS-1:0] status_o,
    output logic             irq_o
);
    logic [NPINS-1:0] status_q;
    logic [NPINS-1:0] keep_mask;

    // Zero bits of a clearing write drop their flag; a hit overrides it.
    assign keep_mask = clr_i ? keep_i : '1;

    always_ff @(posedge clk_i) begin
        if (rst_i) status_q <= '0;
        else       status_q <= (status_q & keep_mask) | hit_i;
    end

    assign status_o = status_q;
    assign irq_o    = |(status_q & en_i);
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic [NPINS-1:0]      pin_i,
    input  logic                  reg_wr_i,
    input  logic [REG_ADDR_W-1:0] reg_addr_i,
    input  logic [NPINS-1:0]      reg_wdata_i,
    output logic [NPINS-1:0]      reg_rdata_o,
    output logic                  irq_o
);
    logic [NPINS-1:0]     sync_lvl;
    logic [NPINS-1:0]     dir_q, en_q, mode_q, pol_q;
    pin_cfg_t [NPINS-1:0] cfg;
    logic [NPINS-1:0]     hit;
    logic [NPINS-1:0]     status_q;
    logic                 clr_wr;

    assign clr_wr = reg_wr_i && (gpio_reg_e'(reg_addr_i) == REG_STATUS);

    gpio_irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (pin_i),
        .q_o   (sync_lvl)
    );

    gpio_irq_regs #(.NPINS(NPINS)) u_regs (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .dir_o   (dir_q),
        .en_o    (en_q),
        .mode_o  (mode_q),
        .pol_o   (pol_q),
        .cfg_o   (cfg)
    );

    gpio_irq_event #(.NPINS(NPINS)) u_event (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (sync_lvl),
        .cfg_i   (cfg),
        .hit_o   (hit)
    );

    gpio_irq_status #(.NPINS(NPINS)) u_status (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .hit_i    (hit),
        .clr_i    (clr_wr),
        .keep_i   (reg_wdata_i),
        .en_i     (en_q),
        .status_o (status_q),
        .irq_o    (irq_o)
    );

    always_comb begin
        case (gpio_reg_e'(reg_addr_i))
            REG_DIR:    reg_rdata_o = dir_q;
            REG_ENABLE: reg_rdata_o = en_q;
            REG_MODE:   reg_rdata_o = mode_q;
            REG_POL:    reg_rdata_o = pol_q;
            REG_STATUS: reg_rdata_o = status_q;
            REG_PINS:   reg_rdata_o = sync_lvl;
            default:    reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
    parameter int unsigned NPINS = 32
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             reg_wr_i,
    input logic [2:0]       reg_addr_i,
    input logic [NPINS-1:0] reg_wdata_i,
    input logic             irq_o,
    input logic [NPINS-1:0] status_q,
    input logic [NPINS-1:0] sync_lvl,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] en_q,
    input logic [NPINS-1:0] mode_q,
    input logic [NPINS-1:0] pol_q
);
    logic [NPINS-1:0] may_drop;
    logic [NPINS-1:0] lvl_want;

    assign may_drop = (reg_wr_i && reg_addr_i == 3'd4) ? ~reg_wdata_i : '0;
    assign lvl_want = mode_q & ~dir_q & (sync_lvl ^ pol_q);

    // R1: reset leaves no flag and no request.
    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (status_q == '0) && !irq_o);

    // R10: request follows enabled flags.
    p_summary_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o == |(status_q & en_q));

    // R7: no new flag on a pin configured as output.
    p_output_quiet_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_q & ~$past(status_q) & $past(dir_q)) == '0);

    // R8: a flag only falls where a clearing write had a zero.
    p_clear_only_zeros_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(status_q) & ~status_q & ~$past(may_drop)) == '0);

    // R6 and R9: an active level leaves the flag set, even over a clear.
    p_level_sets_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(lvl_want) & ~status_q) == '0);
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .irq_o       (irq_o),
    .status_q    (status_q),
    .sync_lvl    (sync_lvl),
    .dir_q       (dir_q),
    .en_q        (en_q),
    .mode_q      (mode_q),
    .pol_q       (pol_q)
);

// File: tb/gpio_irq_detect_bench.sv
`timescale 1ns/1ps
module gpio_irq_detect_bench;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  pins = '0;
    logic          wr = 1'b0;
    logic [2:0]    addr = 3'd4;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gpio_irq_detect u_gpio_irq_detect (
        .clk_i       (clk),
        .rst_i       (rst),
        .pin_i       (pins),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // Behavioural reference model, advanced on every rising edge.
    bit [N-1:0] m_s1, m_s2, m_prev, m_stat, m_dir, m_en, m_mode, m_pol, m_next;
    bit         m_hit;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0;
            m_dir = '0; m_en = '0; m_mode = '0; m_pol = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (m_dir[i])       m_hit = 1'b0;
                else if (m_mode[i]) m_hit = m_pol[i] ? !m_s2[i] : m_s2[i];
                else if (m_pol[i])  m_hit = m_prev[i] && !m_s2[i];
                else                m_hit = !m_prev[i] && m_s2[i];
                if (m_hit)                                m_next[i] = 1'b1;
                else if (wr && addr == 3'd4 && !wdata[i]) m_next[i] = 1'b0;
                else                                      m_next[i] = m_stat[i];
            end
            m_stat = m_next;
            if (wr) begin
                case (addr)
                    3'd0: m_dir  = wdata;
                    3'd1: m_en   = wdata;
                    3'd2: m_mode = wdata;
                    3'd3: m_pol  = wdata;
                    default: ;
                endcase
            end
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pins;
        end
    end

    function automatic bit [N-1:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_dir;
            3'd1: return m_en;
            3'd2: return m_mode;
            3'd3: return m_pol;
            3'd4: return m_stat;
            3'd5: return m_s2;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Continuous comparison against the model after every edge.
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            chk(irq == (|(m_stat & m_en)), "R10 summary", {31'd0, irq}, {31'd0, |(m_stat & m_en)});
            chk(rdata == model_read(addr),
                (addr == 3'd4) ? "R8 status" : (addr == 3'd5) ? "R3 pins" : "R2 config",
                rdata, model_read(addr));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0; addr = 3'd4; wdata = '0;
    endtask

    task automatic set_pin(input int i, input logic v);
        @(negedge clk); pins[i] = v;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
        @(negedge clk); addr = a;
        tick(1);
        v = rdata;
        @(negedge clk); addr = 3'd4;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    logic [N-1:0] v;

    initial begin
        tick(3);
        @(negedge clk); rst = 1'b0;

        // R1: everything reads 0 after reset
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk(v == '0, "R1 reset value", v, '0);
        end
        chk(irq == 1'b0, "R1 irq", {31'd0, irq}, '0);

        wr_reg(3'd1, '1);

        // R3 latency, R4 rising edge
        @(negedge clk); pins[0] = 1'b1;
        tick(1); chk(rdata[0] == 1'b0, "R3 edge k", rdata, '0);
        tick(1); chk(rdata[0] == 1'b0, "R3 edge k+1", rdata, '0);
        tick(1); chk(rdata[0] == 1'b1, "R3 edge k+2", rdata, 32'h1);
        chk(irq == 1'b1, "R10 irq raised", {31'd0, irq}, 32'h1);
        set_pin(0, 1'b0); tick(5);
        chk(rdata == 32'h1, "R4 flag held", rdata, 32'h1);

        // R8 clear by zero, ones untouched
        wr_reg(3'd4, ~32'h1); tick(1);
        chk(rdata == '0, "R8 cleared", rdata, '0);
        chk(irq == 1'b0, "R10 irq dropped", {31'd0, irq}, '0);
        @(negedge clk); pins[0] = 1'b1; pins[6] = 1'b1;
        tick(4);
        chk(rdata == 32'h41, "R4 two flags", rdata, 32'h41);
        wr_reg(3'd4, ~32'h40); tick(1);
        chk(rdata == 32'h1, "R8 ones keep", rdata, 32'h1);
        @(negedge clk); pins[0] = 1'b0; pins[6] = 1'b0;
        wr_reg(3'd4, '0); tick(3);
        chk(rdata == '0, "R4 no fall event", rdata, '0);

        // R5 falling edge
        wr_reg(3'd3, 32'h0000_000A);
        set_pin(1, 1'b1); tick(5);
        chk(rdata[1] == 1'b0, "R5 rise ignored", rdata, '0);
        set_pin(1, 1'b0); tick(4);
        chk(rdata[1] == 1'b1, "R5 fall sets", rdata, 32'h2);

        // R6 level modes
        wr_reg(3'd2, 32'h0000_000C); tick(3);
        chk(rdata[3] == 1'b1, "R6 active low", rdata, 32'h8);
        chk(rdata[2] == 1'b0, "R6 high inactive", rdata, '0);
        set_pin(2, 1'b1); tick(4);
        chk(rdata[2] == 1'b1, "R6 active high", rdata, 32'h4);
        wr_reg(3'd4, ~32'h4);
        chk(rdata[2] == 1'b1, "R6 R9 level beats clear", rdata, 32'h4);
        set_pin(2, 1'b0); tick(4);
        wr_reg(3'd4, ~32'h4); tick(1);
        chk(rdata[2] == 1'b0, "R6 cleared when idle", rdata, '0);
        set_pin(3, 1'b1); tick(4);
        wr_reg(3'd4, ~32'h8); tick(1);
        chk(rdata[3] == 1'b0, "R6 low released", rdata, '0);

        // R9 edge event meets clear in the same cycle
        @(negedge clk); pins[4] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); wr = 1'b1; addr = 3'd4; wdata = ~32'h10;
        tick(1);
        chk(rdata[4] == 1'b1, "R9 set wins", rdata, 32'h10);
        @(negedge clk); wr = 1'b0; wdata = '0;

        // R7 output pins are quiet
        wr_reg(3'd0, 32'h20);
        set_pin(5, 1'b1); tick(5);
        chk(rdata[5] == 1'b0, "R7 output no flag", rdata, '0);
        wr_reg(3'd0, '0); tick(3);
        chk(rdata[5] == 1'b0, "R7 no stale edge", rdata, '0);
        set_pin(5, 1'b0); tick(3);
        set_pin(5, 1'b1); tick(4);
        chk(rdata[5] == 1'b1, "R7 input again", rdata, 32'h20);

        // R10 enable gating
        wr_reg(3'd1, '0); tick(1);
        chk(irq == 1'b0, "R10 all disabled", {31'd0, irq}, '0);
        set_pin(7, 1'b1); tick(4);
        chk(rdata[7] == 1'b1, "R10 latched while disabled", rdata, 32'h80);
        wr_reg(3'd1, 32'h80); tick(1);
        chk(irq == 1'b1, "R10 enabled flag", {31'd0, irq}, 32'h1);
        wr_reg(3'd1, 32'h100); tick(1);
        chk(irq == 1'b0, "R10 other bit only", {31'd0, irq}, '0);

        // R2 readback
        wr_reg(3'd0, 32'hA5A5_0000);
        rd(3'd0, v); chk(v == 32'hA5A5_0000, "R2 dir", v, 32'hA5A5_0000);
        wr_reg(3'd1, 32'h1234_5678);
        rd(3'd1, v); chk(v == 32'h1234_5678, "R2 enable", v, 32'h1234_5678);
        rd(3'd2, v); chk(v == 32'h0000_000C, "R2 mode", v, 32'h0000_000C);
        rd(3'd3, v); chk(v == 32'h0000_000A, "R2 pol", v, 32'h0000_000A);
        rd(3'd5, v); chk(v == pins, "R2 pins", v, pins);
        rd(3'd6, v); chk(v == '0, "R2 spare 6", v, '0);
        rd(3'd7, v); chk(v == '0, "R2 spare 7", v, '0);

        tick(2);
        finish_run();
    end
endmodule